// File: doc/BRIEF.md
# Prescaled Off-First PWM Generator

This block produces one PWM output from the system clock. A prescaler divides the clock by a power of two between 2 and 64 to make a tick. A 16-bit period counter advances once per tick. Every period starts with the output low for a programmable number of ticks. The output is then high until the period ends. Two 16-bit values set the shape of the waveform. The cycle value sets the period length, which is cycle+1 ticks. The off value sets the low phase, which is off+1 ticks. The high phase is therefore cycle−off ticks.

The cycle and off values are plain control inputs, not a data stream, so the block has no valid/ready handshake and applies no back-pressure. While the enable is high, both values are held in shadow registers. The shadows take new input values only when a period completes, so a change in the middle of a period never produces a truncated pulse. While the enable is low, the shadows follow the inputs directly, so the first period after enabling uses whatever values are present at that moment. When the shadowed off value is not strictly below the shadowed cycle value, the pair is illegal and the output stays low.

Top module: `pwm_prescaled`

## Requirements
- R1: The divide select `div_sel` picks the tick rate. Codes 0, 1, 2, 3, 4 and 5 give one tick every 2, 4, 8, 16, 32 and 64 clocks respectively, so the divide ratio is 2^(code+1).
- R2: Codes 6 and 7 on `div_sel` behave exactly like code 0, which is divide-by-2.
- R3: One period lasts cycle+1 ticks. The period counter runs from 0 up to the cycle value and then wraps to 0.
- R4: Each period opens with the output low for off+1 ticks. The output is then high for the remaining cycle−off ticks. Measured from the clock edge at which the enable is first sampled high, the output is high after clock edge k exactly when floor(k/div) mod (cycle+1) > off.
- R5: Whenever the active off value is greater than or equal to the active cycle value, the output stays low for the whole period.
- R6: If the cycle or off input changes while the block is enabled, the running period completes with the old values. The new values take effect from the next period boundary.
- R7: When `en` goes low, `pwm_out` goes low in the same cycle. At the next clock edge the prescaler and the period counter are cleared. A later enable therefore starts a fresh period with its full off phase.
- R8: While `en` is low, the cycle and off inputs load straight into the active registers, so the first period after enabling uses them.
- R9: During reset and immediately after it, `pwm_out` is low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Starts generation when high; stops and clears it when low |
| div_sel | input | 3 | Prescaler code (see R1 and R2) |
| cycle_val | input | 16 | Period length minus one, in ticks |
| off_val | input | 16 | Low-phase length minus one, in ticks |
| pwm_out | output | 1 | PWM waveform |

## Verification
The assertions check five things on every cycle:
- the period counter never passes the active cycle value;
- the counter moves only on a tick;
- the shadow registers change only at a period boundary or while disabled;
- a disable clears both counters and holds the output low;
- an illegal pair keeps the output low, and every rising edge of the output lands on the count just past the off value.

The exact waveform for each divide code, including the fallback codes, and the point at which a value changed mid-run first takes effect can only be shown by the bench's scenarios. Those scenarios compare each sampled output against a closed-form model of the tick index.

// File: rtl/pwm_prescaled_pkg.sv
package pwm_prescaled_pkg;

  localparam int DIV_CODES = 6;

  typedef enum logic [2:0] {
    DIV_2  = 3'd0,
    DIV_4  = 3'd1,
    DIV_8  = 3'd2,
    DIV_16 = 3'd3,
    DIV_32 = 3'd4,
    DIV_64 = 3'd5
  } div_code_e;

  // Terminal count of the prescaler for a select code; unused codes give /2.
  function automatic logic [7:0] div_terminal(input logic [2:0] code);
    logic [7:0] term;
    term = 8'd1;
    for (int i = 0; i < DIV_CODES; i++) begin
      if (code == 3'(i)) term = 8'((2 << i) - 1);
    end
    return term;
  endfunction

endpackage

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm_prescaled_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic [PRE_W-1:0] pre_cnt
);

  logic [7:0]       term_full;
  logic [PRE_W-1:0] term;

  always_comb begin
    term_full = div_terminal(3'(sel));
    term      = term_full[PRE_W-1:0];
  end

  // ">=" keeps a divide change that lands mid-count from waiting a full wrap.
  assign tick = run && (pre_cnt >= term);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) pre_cnt <= '0;
    else                        pre_cnt <= pre_cnt + 1'b1;
  end

endmodule

// File: rtl/pwm_period_core.sv
module pwm_period_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] cyc_in,
  input  logic [CNT_W-1:0] off_in,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cyc_sh,
  output logic [CNT_W-1:0] off_sh
);

  logic wrap;
  assign wrap = tick && (cnt == cyc_sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      cyc_sh <= '0;
      off_sh <= '0;
    end else if (!run) begin
      cnt    <= '0;
      cyc_sh <= cyc_in;
      off_sh <= off_in;
    end else if (wrap) begin
      cnt    <= '0;
      cyc_sh <= cyc_in;
      off_sh <= off_in;
    end else if (tick) begin
      cnt    <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int CNT_W = 16
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cyc_sh,
  input  logic [CNT_W-1:0] off_sh,
  output logic             level
);

  logic legal;
  assign legal = off_sh < cyc_sh;
  assign level = run && legal && (cnt > off_sh);

endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0] cycle_val,
  input  logic [CNT_W-1:0] off_val,
  output logic             pwm_out
);

  logic             tick;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cyc_sh;
  logic [CNT_W-1:0] off_sh;

  pwm_tick_div #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .sel     (div_sel),
    .tick    (tick),
    .pre_cnt (pre_cnt)
  );

  pwm_period_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (en),
    .tick   (tick),
    .cyc_in (cycle_val),
    .off_in (off_val),
    .cnt    (cnt),
    .cyc_sh (cyc_sh),
    .off_sh (off_sh)
  );

  pwm_compare #(.CNT_W(CNT_W)) u_cmp (
    .run    (en),
    .cnt    (cnt),
    .cyc_sh (cyc_sh),
    .off_sh (off_sh),
    .level  (pwm_out)
  );

endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pwm_out,
  input logic             tick,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cyc_sh,
  input logic [CNT_W-1:0] off_sh
);

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && pre_cnt == '0)); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out); // R7

  AST_BAD_PAIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (off_sh >= cyc_sh) |-> !pwm_out); // R5

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cyc_sh); // R3

  AST_CNT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt)); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(tick && cnt == cyc_sh)) |=> ($stable(cyc_sh) && $stable(off_sh))); // R6

  AST_RISE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (32'(cnt) == 32'(off_sh) + 1)); // R4

endmodule

bind pwm_prescaled pwm_prescaled_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .pwm_out (pwm_out),
  .tick    (tick),
  .pre_cnt (pre_cnt),
  .cnt     (cnt),
  .cyc_sh  (cyc_sh),
  .off_sh  (off_sh)
);

// File: tb/pwm_prescaled_bench.sv
`timescale 1ns/1ps
module pwm_prescaled_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic [15:0] cycle_val = 16'd0;
  logic [15:0] off_val = 16'd0;
  logic        pwm_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pwm_prescaled u_pwm_prescaled (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .div_sel   (div_sel),
    .cycle_val (cycle_val),
    .off_val   (off_val),
    .pwm_out   (pwm_out)
  );

  // {sel, cycle, off}
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 16'd3, 16'd1},
    {3'd1, 16'd4, 16'd0},
    {3'd2, 16'd2, 16'd1},
    {3'd3, 16'd1, 16'd0},
    {3'd4, 16'd2, 16'd0},
    {3'd5, 16'd1, 16'd0},
    {3'd6, 16'd3, 16'd2},
    {3'd7, 16'd2, 16'd1},
    {3'd0, 16'd2, 16'd2},
    {3'd0, 16'd1, 16'd3},
    {3'd0, 16'd0, 16'd0}
  };

  function automatic int div_of(input int sel);
    return (sel <= 5) ? (2 << sel) : 2;
  endfunction

  function automatic bit model(input int k, input int dv, input int cyc, input int off);
    if (off >= cyc) return 1'b0;
    return ((k / dv) % (cyc + 1)) > off;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Assumes en was just raised at a negedge; checks nk samples against the model.
  task automatic run_seq(input int sel, input int cyc, input int off, input int nk, input string req);
    int bad = 0;
    int fk = -1;
    int fa = 0;
    int fe = 0;
    for (int k = 1; k <= nk; k++) begin
      @(negedge clk);
      if (pwm_out !== model(k, div_of(sel), cyc, off)) begin
        if (bad == 0) begin
          fk = k;
          fa = int'(pwm_out);
          fe = int'(model(k, div_of(sel), cyc, off));
        end
        bad++;
      end
    end
    if (bad != 0) $display("  first mismatch at clock %0d (sel=%0d cyc=%0d off=%0d)", fk, sel, cyc, off);
    check(bad == 0, req, fa, fe);
  endtask

  task automatic run_vec(input int sel, input int cyc, input int off, input string req);
    @(negedge clk);
    en = 1'b0;
    div_sel = 3'(sel);
    cycle_val = 16'(cyc);
    off_val = 16'(off);
    @(negedge clk);
    en = 1'b1;
    run_seq(sel, cyc, off, 2 * (cyc + 1) * div_of(sel), req);
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    en = 1'b1;
    cycle_val = 16'd3;
    off_val = 16'd0;
    repeat (4) @(negedge clk);
    check(pwm_out == 1'b0, "R9 during reset", int'(pwm_out), 0);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out == 1'b0, "R9 after reset", int'(pwm_out), 0);

    // Table walk: each entry loaded while disabled (R8), then two periods checked.
    for (int i = 0; i < NV; i++) begin
      int s = int'(VEC[i][34:32]);
      int c = int'(VEC[i][31:16]);
      int o = int'(VEC[i][15:0]);
      string tag;
      if (o >= c)      tag = "R5 illegal pair";
      else if (s > 5)  tag = "R2 fallback code";
      else             tag = "R1 R3 R4 R8 waveform";
      run_vec(s, c, o, tag);
    end

    // R6: change values mid-period; new pair applies from clock 8 on.
    @(negedge clk);
    en = 1'b0;
    div_sel = 3'd0;
    cycle_val = 16'd3;
    off_val = 16'd1;
    @(negedge clk);
    en = 1'b1;
    begin
      int bad = 0;
      for (int k = 1; k <= 32; k++) begin
        bit e;
        @(negedge clk);
        e = (k < 8) ? (((k / 2) % 4) > 1) : ((((k - 8) / 2) % 6) > 2);
        if (pwm_out !== e) bad++;
        if (k == 3) begin
          cycle_val = 16'd5;
          off_val = 16'd2;
        end
      end
      check(bad == 0, "R6 boundary update", bad, 0);
    end

    // R7: disable in the high phase, then re-enable for a fresh period.
    @(negedge clk);
    en = 1'b0;
    cycle_val = 16'd3;
    off_val = 16'd0;
    @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
    check(pwm_out == 1'b1, "R4 high before disable", int'(pwm_out), 1);
    en = 1'b0;
    #1;
    check(pwm_out == 1'b0, "R7 immediate low", int'(pwm_out), 0);
    @(negedge clk);
    check(pwm_out == 1'b0, "R7 stays low", int'(pwm_out), 0);
    en = 1'b1;
    run_seq(0, 3, 0, 16, "R7 restart with full off phase");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule